// File: doc/BRIEF.md
# Multithreaded Issue-Queue Occupancy Allocator

This block keeps the books for a shared issue queue in a multithreaded core. It does not hold instructions. It counts how many queue slots each hardware thread occupies and how many slots remain free in total. It also enforces a per-thread ceiling on occupancy. Upstream dispatch sends an allocate pulse tagged with a thread number. The issue and flush logic send release and squash-release pulses, also tagged with a thread number. The block answers with full flags and free counts, both global and per thread, so that dispatch can stall before it overruns a thread's share.

The per-thread ceiling comes from a static sharing policy. The shared policy lets any thread use the whole queue. The split policy divides the queue evenly among the threads that are currently active. The percentage policy gives each thread a programmed fraction of the queue, and a thread that is running alone gets the whole queue. Ceilings are recomputed from the policy, the percentage and the active-thread mask, and a change takes effect at the next clock edge. An allocation that would overrun a ceiling is refused and flagged. A release against an empty thread count is also refused and flagged.

Top module: `iqa_alloc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `free_o` equals N_ENTRIES, every per-thread free count equals that thread's ceiling, and both error flags are 0.
- R2: With `policy_i` equal to 0 or 3 (shared), every thread's ceiling is N_ENTRIES.
- R3: With `policy_i` equal to 1 (split), let k be the number of set bits in `active_i`. When k > 0, an active thread's ceiling is floor(N_ENTRIES/k). Inactive threads, and all threads when k = 0, get floor(N_ENTRIES/N_THREADS).
- R4: With `policy_i` equal to 2 (percentage), every thread's ceiling is floor(min(`pct_i`,100)·N_ENTRIES/100). The exception is when exactly one bit of `active_i` is set: that thread's ceiling is N_ENTRIES.
- R5: Ceilings are sampled from `policy_i`, `pct_i` and `active_i` at each rising edge. They show in the outputs right after that edge.
- R6: An allocation is accepted when `free_o` > 0 and the thread's count is below its ceiling. It raises that thread's count by one and lowers `free_o` by one after the edge.
- R7: A refused allocation leaves all counts unchanged. It sets `ovf_err_o` for the one cycle after the edge. An allocation tagged with a thread number of N_THREADS or more is also refused.
- R8: A release or squash-release lowers the tagged thread's count by one and raises `free_o` by one. When both name the same thread, the release is applied first. A pulse that finds the count already at zero is ignored and sets `unf_err_o` for one cycle.
- R9: `full_o` is 1 exactly when `free_o` is 0. A thread's free count is its ceiling minus its count, saturating at 0. `thr_full_o[t]` is 1 exactly when that free count is 0. Thread t's free count sits in bits [t·CW +: CW] of `thr_free_o`, where CW = clog2(N_ENTRIES+1).
- R10: An allocation and a release in the same cycle are each judged on the state before the edge. A release does not make room for a same-cycle allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Sharing policy: 0/3 shared, 1 split, 2 percentage |
| pct_i | input | 7 | Percentage for the percentage policy (values above 100 are treated as 100) |
| active_i | input | N_THREADS | Active-thread mask |
| alloc_i | input | 1 | Allocate one slot |
| alloc_tid_i | input | TW | Thread of the allocation |
| rel_i | input | 1 | Release one slot |
| rel_tid_i | input | TW | Thread of the release |
| sq_i | input | 1 | Squash-release one slot |
| sq_tid_i | input | TW | Thread of the squash-release |
| full_o | output | 1 | Whole queue full |
| thr_full_o | output | N_THREADS | Per-thread full flags |
| free_o | output | CW | Global free slot count |
| thr_free_o | output | N_THREADS·CW | Per-thread free counts, packed |
| ovf_err_o | output | 1 | An allocation was refused last cycle |
| unf_err_o | output | 1 | A release was refused last cycle |

## Verification
The bench targets ceilings that shrink below a thread's current count. If the free count were not saturated, it would wrap to a large value and let dispatch overrun the queue. The bench sends a release and a squash-release to a thread holding one entry. A design that counted both would underflow the count. It allocates and releases at a full thread in the same cycle, which a design that judged on post-release state would wrongly accept. It also covers split ceilings with 3 active threads, where integer rounding matters. In the percentage policy it drives a percentage of 0, a percentage above 100, and a single active thread. A percentage above 100 that was not clamped would give a ceiling larger than the queue.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
   typedef enum logic [1:0] {
      POL_SHARED     = 2'd0,
      POL_SPLIT      = 2'd1,
      POL_PCT        = 2'd2,
      POL_SHARED_ALT = 2'd3
   } pol_e;
endpackage

// File: rtl/iqa_cap_calc.sv
module iqa_cap_calc
   import iqa_pkg::*;
#(
   parameter int N = 4,
   parameter int E = 16,
   parameter int CW = $clog2(E + 1)
) (
   input  logic [1:0]    pol_i,
   input  logic [6:0]    pct_i,
   input  logic [N-1:0]  act_i,
   output logic [CW-1:0] cap_o [N]
);
   localparam int KW = $clog2(N + 1);
   localparam int PW = CW + 7;

   logic [KW-1:0] n_act;
   logic [CW-1:0] split_tab [N+1];
   logic [6:0]    pct_c;
   logic [PW-1:0] prod;
   logic [CW-1:0] pct_cap;

   always_comb begin
      n_act = '0;
      for (int i = 0; i < N; i++) n_act = n_act + KW'(act_i[i]);
   end

   // Quotients by a constant divisor, one per possible active count
   for (genvar k = 0; k <= N; k++) begin : g_tab
      localparam int DIV = (k == 0) ? N : k;
      assign split_tab[k] = CW'(E / DIV);
   end

   assign pct_c   = (pct_i > 7'd100) ? 7'd100 : pct_i;
   assign prod    = PW'(pct_c) * PW'(E);
   assign pct_cap = CW'(prod / PW'(100));

   for (genvar t = 0; t < N; t++) begin : g_thr
      always_comb begin
         case (pol_e'(pol_i))
            POL_SPLIT: cap_o[t] = (n_act != '0 && act_i[t]) ? split_tab[n_act] : split_tab[0];
            POL_PCT:   cap_o[t] = (n_act == KW'(1) && act_i[t]) ? CW'(E) : pct_cap;
            default:   cap_o[t] = CW'(E);
         endcase
      end
   end
endmodule

// File: rtl/iqa_thread_ctr.sv
module iqa_thread_ctr #(
   parameter int E = 16,
   parameter int CW = $clog2(E + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cap_i,
   input  logic          room_i,
   input  logic          alloc_hit_i,
   input  logic          rel_hit_i,
   input  logic          sq_hit_i,
   output logic          alloc_ok_o,
   output logic          rel_ok_o,
   output logic          sq_ok_o,
   output logic [CW-1:0] free_o
);
   logic [CW-1:0] cap_q;
   logic [CW-1:0] cnt_q;

   assign rel_ok_o   = rel_hit_i && (cnt_q != '0);
   assign sq_ok_o    = sq_hit_i && (cnt_q > (rel_ok_o ? CW'(1) : CW'(0)));
   assign alloc_ok_o = alloc_hit_i && room_i && (cnt_q < cap_q);
   assign free_o     = (cap_q > cnt_q) ? (cap_q - cnt_q) : '0;

   always_ff @(posedge clk) cap_q <= cap_i;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CW'(alloc_ok_o) - CW'(rel_ok_o) - CW'(sq_ok_o);
   end
endmodule

// File: rtl/iqa_alloc.sv
module iqa_alloc
   import iqa_pkg::*;
#(
   parameter int N_THREADS = 4,
   parameter int N_ENTRIES = 16,
   localparam int TW = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
   localparam int CW = $clog2(N_ENTRIES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             policy_i,
   input  logic [6:0]             pct_i,
   input  logic [N_THREADS-1:0]   active_i,
   input  logic                   alloc_i,
   input  logic [TW-1:0]          alloc_tid_i,
   input  logic                   rel_i,
   input  logic [TW-1:0]          rel_tid_i,
   input  logic                   sq_i,
   input  logic [TW-1:0]          sq_tid_i,
   output logic                   full_o,
   output logic [N_THREADS-1:0]   thr_full_o,
   output logic [CW-1:0]          free_o,
   output logic [N_THREADS*CW-1:0] thr_free_o,
   output logic                   ovf_err_o,
   output logic                   unf_err_o
);
   localparam int SW = CW + 2;

   if (N_THREADS < 2)         begin : g_bad_n  $error("N_THREADS must be at least 2"); end
   if (N_ENTRIES < N_THREADS) begin : g_bad_e  $error("N_ENTRIES must be at least N_THREADS"); end

   logic [CW-1:0]        cap_c [N_THREADS];
   logic [N_THREADS-1:0] a_ok, r_ok, s_ok;
   logic [CW-1:0]        free_q;
   logic                 ovf_q, unf_q;
   logic [SW-1:0]        free_nxt;

   iqa_cap_calc #(.N(N_THREADS), .E(N_ENTRIES), .CW(CW)) u_cap (
      .pol_i (policy_i),
      .pct_i (pct_i),
      .act_i (active_i),
      .cap_o (cap_c)
   );

   for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
      logic [CW-1:0] tf;
      iqa_thread_ctr #(.E(N_ENTRIES), .CW(CW)) u_ctr (
         .clk         (clk),
         .rst_n       (rst_n),
         .cap_i       (cap_c[t]),
         .room_i      (free_q != '0),
         .alloc_hit_i (alloc_i && (alloc_tid_i == TW'(t))),
         .rel_hit_i   (rel_i && (rel_tid_i == TW'(t))),
         .sq_hit_i    (sq_i && (sq_tid_i == TW'(t))),
         .alloc_ok_o  (a_ok[t]),
         .rel_ok_o    (r_ok[t]),
         .sq_ok_o     (s_ok[t]),
         .free_o      (tf)
      );
      assign thr_free_o[t*CW +: CW] = tf;
      assign thr_full_o[t]          = (tf == '0);
   end

   always_comb begin
      free_nxt = SW'(free_q);
      for (int t = 0; t < N_THREADS; t++)
         free_nxt = free_nxt + SW'(r_ok[t]) + SW'(s_ok[t]) - SW'(a_ok[t]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= CW'(N_ENTRIES);
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         free_q <= CW'(free_nxt);
         ovf_q  <= alloc_i && (a_ok == '0);
         unf_q  <= (rel_i && (r_ok == '0)) || (sq_i && (s_ok == '0));
      end
   end

   assign free_o    = free_q;
   assign full_o    = (free_q == '0);
   assign ovf_err_o = ovf_q;
   assign unf_err_o = unf_q;
endmodule

// File: rtl/iqa_alloc_chk.sv
module iqa_alloc_chk #(
   parameter int N = 4,
   parameter int E = 16,
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          alloc_i,
   input logic          rel_i,
   input logic          sq_i,
   input logic          full_o,
   input logic [N-1:0]  thr_full_o,
   input logic [CW-1:0] free_o,
   input logic [N*CW-1:0] thr_free_o,
   input logic          ovf_err_o,
   input logic          unf_err_o
);
   a_r9_full_tracks_free: assert property (@(posedge clk) disable iff (!rst_n)
      full_o == (free_o == '0));

   a_r6_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      free_o <= CW'(E));

   a_r6_idle_holds_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_i && !rel_i && !sq_i) |=> $stable(free_o));

   a_r7_full_alloc_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_i && full_o) |=> ovf_err_o);

   a_r8_unf_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err_o |-> $past(rel_i || sq_i));

   a_r8_release_never_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_i && (rel_i || sq_i)) |=> (free_o >= $past(free_o)));

   for (genvar t = 0; t < N; t++) begin : g_t
      a_r9_thr_full_tracks_free: assert property (@(posedge clk) disable iff (!rst_n)
         thr_full_o[t] == (thr_free_o[t*CW +: CW] == '0));
   end
endmodule

bind iqa_alloc iqa_alloc_chk #(.N(N_THREADS), .E(N_ENTRIES), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_i    (alloc_i),
   .rel_i      (rel_i),
   .sq_i       (sq_i),
   .full_o     (full_o),
   .thr_full_o (thr_full_o),
   .free_o     (free_o),
   .thr_free_o (thr_free_o),
   .ovf_err_o  (ovf_err_o),
   .unf_err_o  (unf_err_o)
);

// File: tb/iqa_alloc_test.sv
module iqa_alloc_test;
   localparam int PERIOD = 10;
   localparam int N  = 4;
   localparam int E  = 16;
   localparam int TW = 2;
   localparam int CW = $clog2(E + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    pol = 2'd0;
   logic [6:0]    pct = 7'd0;
   logic [N-1:0]  act = '1;
   logic          al = 1'b0, rl = 1'b0, sq = 1'b0;
   logic [TW-1:0] atid = '0, rtid = '0, stid = '0;

   logic          full_w, ovf_w, unf_w;
   logic [N-1:0]  tfull_w;
   logic [CW-1:0] free_w;
   logic [N*CW-1:0] tfree_w;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   int mcap [N];
   int mcnt [N];
   int mfree;
   bit movf, munf;

   always #(PERIOD/2) clk = ~clk;

   iqa_alloc #(.N_THREADS(N), .N_ENTRIES(E)) uut (
      .clk(clk), .rst_n(rst_n), .policy_i(pol), .pct_i(pct), .active_i(act),
      .alloc_i(al), .alloc_tid_i(atid), .rel_i(rl), .rel_tid_i(rtid),
      .sq_i(sq), .sq_tid_i(stid), .full_o(full_w), .thr_full_o(tfull_w),
      .free_o(free_w), .thr_free_o(tfree_w), .ovf_err_o(ovf_w), .unf_err_o(unf_w)
   );

   function automatic int cap_of(int t);
      int k = 0;
      int p;
      for (int i = 0; i < N; i++) k += act[i];
      case (pol)
         2'd1: return (k > 0 && act[t]) ? E / k : E / N;
         2'd2: begin
            if (k == 1 && act[t]) return E;
            p = (pct > 100) ? 100 : int'(pct);
            return (p * E) / 100;
         end
         default: return E;
      endcase
   endfunction

   task automatic chk(string req, int actual, int expv);
      n_chk++;
      if (actual != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expv, $time);
      end
   endtask

   task automatic model_edge();
      bit aok, rok, sok;
      if (!rst_n) begin
         for (int t = 0; t < N; t++) mcnt[t] = 0;
         mfree = E; movf = 0; munf = 0;
      end else begin
         aok = al && (int'(atid) < N) && mfree > 0 && mcnt[atid] < mcap[atid];
         rok = rl && mcnt[rtid] > 0;
         sok = sq && (mcnt[stid] - ((rok && rtid == stid) ? 1 : 0)) > 0;
         if (aok) mcnt[atid]++;
         if (rok) mcnt[rtid]--;
         if (sok) mcnt[stid]--;
         mfree = mfree + rok + sok - aok;
         movf = al && !aok;
         munf = (rl && !rok) || (sq && !sok);
      end
      for (int t = 0; t < N; t++) mcap[t] = cap_of(t);
   endtask

   // one clock: model at the edge, compare at the falling edge
   task automatic step(string tag);
      int ef;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      for (int t = 0; t < N; t++) begin
         ef = (mcap[t] > mcnt[t]) ? mcap[t] - mcnt[t] : 0;
         chk(tag, int'(tfree_w[t*CW +: CW]), ef);
         chk("R9 thread full", int'(tfull_w[t]), int'(ef == 0));
      end
      chk("R6 global free", int'(free_w), mfree);
      chk("R9 global full", int'(full_w), int'(mfree == 0));
      chk("R7 overflow flag", int'(ovf_w), int'(movf));
      chk("R8 underflow flag", int'(unf_w), int'(munf));
   endtask

   task automatic ops(bit a, int at, bit r, int rt, bit s, int st);
      al = a; atid = TW'(at); rl = r; rtid = TW'(rt); sq = s; stid = TW'(st);
   endtask

   task automatic fill(int tid, int n, string tag);
      for (int i = 0; i < n; i++) begin
         ops(1, tid, 0, 0, 0, 0);
         step(tag);
      end
      ops(0, 0, 0, 0, 0, 0);
   endtask

   task automatic drain(int tid, int n, string tag);
      for (int i = 0; i < n; i++) begin
         ops(0, 0, 1, tid, 0, 0);
         step(tag);
      end
      ops(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step("R1 reset");
      step("R1 reset");
      rst_n = 1'b1;
      step("R1 first cycle");

      // R2 shared: one thread can take the whole queue; overflow past it
      pol = 2'd0;
      fill(0, E + 1, "R2 shared ceiling");
      ops(1, 2, 0, 0, 0, 0); step("R7 alloc while full");
      ops(0, 0, 0, 0, 0, 0); step("R7 flag clears");
      drain(0, E + 1, "R8 drain past zero");
      pol = 2'd3; step("R2 alt code");
      fill(3, 5, "R2 alt code");
      drain(3, 5, "R2 alt code");

      // R3 split, all active: 4 each
      pol = 2'd1; act = 4'b1111; step("R5 policy change");
      fill(1, 5, "R3 split four");
      // R10: full thread, alloc and release together
      ops(1, 1, 1, 1, 0, 0); step("R10 same cycle");
      ops(0, 0, 0, 0, 0, 0); step("R10 after");
      // R3 with two active: 8 for active threads
      act = 4'b0011; step("R5 mask change");
      fill(1, 6, "R3 split two");
      act = 4'b0111; step("R3 split three");
      fill(2, 6, "R3 split three");
      act = 4'b0000; step("R3 none active");
      act = 4'b1111; step("R9 cap below count");
      // R8 release and squash on a one-entry thread
      ops(1, 3, 0, 0, 0, 0); step("R6 alloc");
      ops(0, 0, 1, 3, 1, 3); step("R8 double release");
      ops(0, 0, 1, 1, 1, 2); step("R8 two threads");
      ops(0, 0, 0, 0, 0, 0);
      drain(1, 8, "R8 drain");
      drain(2, 6, "R8 drain");

      // R4 percentage
      pol = 2'd2; pct = 7'd50; act = 4'b1111; step("R4 half");
      fill(0, 9, "R4 half");
      pct = 7'd33; step("R4 third");
      pct = 7'd0; step("R4 zero");
      fill(2, 1, "R4 zero");
      pct = 7'd120; step("R4 clamp");
      fill(2, 9, "R4 clamp");
      pct = 7'd25; act = 4'b0100; step("R4 single active");
      fill(2, 9, "R4 single active");
      act = 4'b0110; step("R4 two active");
      drain(0, 9, "R4 drain");
      drain(2, 17, "R4 drain");

      // mixed traffic with policy changes
      for (int i = 0; i < 600; i++) begin
         if (i % 37 == 0) begin
            pol = 2'($urandom_range(0, 3));
            pct = 7'($urandom_range(0, 127));
            act = 4'($urandom_range(0, 15));
         end
         ops($urandom_range(0, 2) != 0, $urandom_range(0, 3),
             $urandom_range(0, 2) == 0, $urandom_range(0, 3),
             $urandom_range(0, 3) == 0, $urandom_range(0, 3));
         step("R5 mixed traffic");
      end
      ops(0, 0, 0, 0, 0, 0);
      rst_n = 1'b0; step("R1 re-reset");
      rst_n = 1'b1; step("R1 re-reset");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule